// File: doc/BRIEF.md
# Device-Side Link Speed Negotiator

This block is the peripheral end of an out-of-band link bring-up. It watches flags from a signal detector that report host reset bursts, the end of a reset episode and the end of a host wake episode. It then drives the transmit side through one-cycle burst request strobes, a speed select and primitive selects. A reset episode that is long enough is answered with an initialization request made of bursts. A host wake is answered with an optional calibrate strobe and then a fixed run of wake bursts. After that the block offers ALIGN primitives at each supported speed in turn, starting with the fastest.

Speed negotiation steps down through the generations enabled in a parameter mask, and each speed gets a fixed response window. If the host sends ALIGN back, the block locks for one cycle and then sends SYNC and raises `link_up`. If every enabled speed times out, the block enters an error state. That state holds until the host starts a new reset episode. The burst interface is a plain request/done pair: a request strobe lasts one cycle, and the next request is not raised until `tx_burst_done` has acknowledged the previous one, so the transmitter sets the pace.

Top module: `oob_speed_negotiator`

## Requirements
- R1: After reset every output is low except `speed_sel`, which holds the highest supported generation. `speed_sel` value g selects generation g+1, and bit g of `SPEED_MASK` enables it.
- R2: A reset episode counts `rst_burst_det` pulses. On `rst_release_det`, the block starts the initialization request if the count is at least `MIN_RST_BURSTS` (6). A shorter episode is discarded and the block returns to idle.
- R3: The initialization request is exactly `INIT_BURSTS` (6) strobes on `init_burst_req`, each one cycle long. Each strobe waits for the `tx_burst_done` of the previous one. The block then issues no further requests until a host wake ends.
- R4: In the cycle after `wake_release_det`, `cal_req` pulses for one cycle (when `CAL_EN` is 1). Exactly `WAKE_BURSTS` (6) `wake_burst_req` strobes follow, using the same handshake.
- R5: In the cycle after the last wake burst is acknowledged, `send_align` rises with `speed_sel` at the highest supported generation.
- R6: Each offered speed lasts exactly `WINDOW` cycles. On expiry, `speed_sel` moves to the next lower generation enabled in the mask and skips disabled ones.
- R7: `rx_d10_2` has no effect on the speed sequence or on its timing.
- R8: When the lowest enabled speed expires, `link_err` rises and `send_align` falls. `link_err` stays high against `rx_align`, `wake_release_det` and the passage of time.
- R9: If `rx_align` is high during an ALIGN cycle, including the last cycle of the last window, the next cycle is a lock cycle. In that cycle `send_align` stays high and `speed_sel` is held. From the following cycle onward, `send_sync` and `link_up` are high and stay high.
- R10: A `rst_burst_det` in any state aborts the current activity in the next cycle. This clears `link_up` and `link_err`, and negotiation restarts from the reset episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rst_burst_det | input | 1 | One pulse per host reset burst detected |
| rst_release_det | input | 1 | Pulse when the host reset episode has ended |
| wake_release_det | input | 1 | Pulse when the host wake episode has ended |
| tx_burst_done | input | 1 | Transmitter finished the requested burst |
| rx_d10_2 | input | 1 | Host D10.2 filler is being received |
| rx_align | input | 1 | Host ALIGN primitive received |
| init_burst_req | output | 1 | One-cycle request for one initialization burst |
| wake_burst_req | output | 1 | One-cycle request for one wake burst |
| cal_req | output | 1 | One-cycle calibrate strobe before the wake bursts |
| speed_sel | output | 2 | Selected generation minus one |
| send_align | output | 1 | Transmit ALIGN primitives |
| send_sync | output | 1 | Transmit SYNC primitives |
| link_up | output | 1 | Link established |
| link_err | output | 1 | No supported speed was accepted |

## Verification
Reset episodes of every length from zero to eight bursts show where the six-burst threshold lies, and they confirm that short episodes leave no trace. A full negotiation run that the host never answers, with D10.2 filler held high throughout, tests the per-speed window length, the skip over the disabled middle generation and entry into the sticky error. A second sweep injects the host ALIGN at every cycle offset across both windows. This shows which speed the lock captures, including the final cycle where the answer and the timeout coincide. Each run of that sweep starts from an established link, which also tests the abort on a new reset burst.

// File: rtl/oobn_pkg.sv
package oobn_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_INIT, ST_WWAKE, ST_CAL,
    ST_WAKE, ST_ALIGN, ST_LOCK, ST_SYNC, ST_ERR
  } neg_state_t;
endpackage

// File: rtl/oobn_burst_seq.sv
module oobn_burst_seq #(
  parameter int N = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic burst_done,
  output logic burst_req,
  output logic seq_done
);
  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;
  logic          pend;

  assign seq_done  = (cnt == CW'(N));
  assign burst_req = active && !pend && !seq_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (!active) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else if (burst_req) begin
      pend <= 1'b1;
    end else if (pend && burst_done) begin
      pend <= 1'b0;
      cnt  <= cnt + 1'b1;
    end
  end

  // a request is a single-cycle strobe; the next waits for done
  assert_req_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_req |=> !burst_req);
endmodule

// File: rtl/oobn_window_timer.sv
module oobn_window_timer #(
  parameter int WINDOW = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [TW-1:0] cnt;

  assign expired = run && (cnt == TW'(WINDOW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || expired) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/oobn_speed_pick.sv
module oobn_speed_pick #(
  parameter logic [2:0] MASK = 3'b111
) (
  input  logic [1:0] cur,
  output logic [1:0] top_spd,
  output logic [1:0] lower_spd,
  output logic       has_lower
);
  always_comb begin
    top_spd   = 2'd0;
    lower_spd = 2'd0;
    has_lower = 1'b0;
    for (int g = 0; g < 3; g++) begin
      if (MASK[g]) top_spd = 2'(g);
      if (MASK[g] && (2'(g) < cur)) begin
        lower_spd = 2'(g);
        has_lower = 1'b1;
      end
    end
  end
endmodule

// File: rtl/oob_speed_negotiator.sv
module oob_speed_negotiator #(
  parameter logic [2:0] SPEED_MASK     = 3'b111,
  parameter int         WINDOW         = 1024,
  parameter int         MIN_RST_BURSTS = 6,
  parameter int         INIT_BURSTS    = 6,
  parameter int         WAKE_BURSTS    = 6,
  parameter bit         CAL_EN         = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_burst_det,
  input  logic       rst_release_det,
  input  logic       wake_release_det,
  input  logic       tx_burst_done,
  input  logic       rx_d10_2,
  input  logic       rx_align,
  output logic       init_burst_req,
  output logic       wake_burst_req,
  output logic       cal_req,
  output logic [1:0] speed_sel,
  output logic       send_align,
  output logic       send_sync,
  output logic       link_up,
  output logic       link_err
);
  import oobn_pkg::*;

  localparam int RCW = $clog2(MIN_RST_BURSTS + 1);

  neg_state_t     state, nxt;
  logic [RCW-1:0] rcnt;
  logic [1:0]     spd, top_spd, lower_spd;
  logic           has_lower, expired;
  logic           init_req, init_done, wake_req, wake_done;

  oobn_speed_pick #(.MASK(SPEED_MASK)) u_pick (
    .cur(spd), .top_spd(top_spd), .lower_spd(lower_spd), .has_lower(has_lower)
  );

  oobn_window_timer #(.WINDOW(WINDOW)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state == ST_ALIGN), .expired(expired)
  );

  oobn_burst_seq #(.N(INIT_BURSTS)) u_init_seq (
    .clk(clk), .rst_n(rst_n), .active(state == ST_INIT),
    .burst_done(tx_burst_done), .burst_req(init_req), .seq_done(init_done)
  );

  oobn_burst_seq #(.N(WAKE_BURSTS)) u_wake_seq (
    .clk(clk), .rst_n(rst_n), .active(state == ST_WAKE),
    .burst_done(tx_burst_done), .burst_req(wake_req), .seq_done(wake_done)
  );

  always_comb begin
    nxt = state;
    if (rst_burst_det) nxt = ST_RST;
    else begin
      unique case (state)
        ST_RST:   if (rst_release_det)
                    nxt = (rcnt == RCW'(MIN_RST_BURSTS)) ? ST_INIT : ST_IDLE;
        ST_INIT:  if (init_done) nxt = ST_WWAKE;
        ST_WWAKE: if (wake_release_det) nxt = CAL_EN ? ST_CAL : ST_WAKE;
        ST_CAL:   nxt = ST_WAKE;
        ST_WAKE:  if (wake_done) nxt = ST_ALIGN;
        ST_ALIGN: if (rx_align) nxt = ST_LOCK;
                  else if (expired && !has_lower) nxt = ST_ERR;
        ST_LOCK:  nxt = ST_SYNC;
        default:  nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rcnt  <= '0;
      spd   <= top_spd;
    end else begin
      state <= nxt;
      if (rst_burst_det) begin
        if (state != ST_RST)                      rcnt <= RCW'(1);
        else if (rcnt != RCW'(MIN_RST_BURSTS))   rcnt <= rcnt + 1'b1;
      end
      if (state == ST_WAKE && wake_done && !rst_burst_det)
        spd <= top_spd;
      else if (state == ST_ALIGN && !rx_align && !rst_burst_det && expired && has_lower)
        spd <= lower_spd;
    end
  end

  assign init_burst_req = init_req;
  assign wake_burst_req = wake_req;
  assign cal_req        = (state == ST_CAL);
  assign speed_sel      = spd;
  assign send_align     = (state == ST_ALIGN) || (state == ST_LOCK);
  assign send_sync      = (state == ST_SYNC);
  assign link_up        = (state == ST_SYNC);
  assign link_err       = (state == ST_ERR);

  assert_one_req_kind_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_burst_req && wake_burst_req));

  assert_cal_then_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_req && !rst_burst_det) |=> wake_burst_req);

  assert_align_supported_R6: assert property (@(posedge clk) disable iff (!rst_n)
    send_align |-> SPEED_MASK[speed_sel]);

  assert_speed_never_rises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ALIGN && $past(state) == ST_ALIGN) |-> (speed_sel <= $past(speed_sel)));

  // filler from the host is not an answer: without ALIGN or expiry we stay
  assert_d10_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ALIGN && rx_d10_2 && !rx_align && !expired && !rst_burst_det)
      |=> (state == ST_ALIGN && $stable(speed_sel)));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_err && !rst_burst_det) |=> link_err);

  assert_sync_after_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(send_sync) |-> $past(send_align));
endmodule

// File: tb/oob_speed_negotiator_bench.sv
module oob_speed_negotiator_bench;
  localparam logic [2:0] MASK = 3'b101;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rst_burst_det = 0, rst_release_det = 0, wake_release_det = 0;
  logic tx_burst_done = 0, rx_d10_2 = 0, rx_align = 0;
  logic init_burst_req, wake_burst_req, cal_req, send_align, send_sync, link_up, link_err;
  logic [1:0] speed_sel;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  oob_speed_negotiator #(.SPEED_MASK(MASK), .WINDOW(WIN), .CAL_EN(1'b1)) u_oob_speed_negotiator (
    .clk(clk), .rst_n(rst_n), .rst_burst_det(rst_burst_det),
    .rst_release_det(rst_release_det), .wake_release_det(wake_release_det),
    .tx_burst_done(tx_burst_done), .rx_d10_2(rx_d10_2), .rx_align(rx_align),
    .init_burst_req(init_burst_req), .wake_burst_req(wake_burst_req),
    .cal_req(cal_req), .speed_sel(speed_sel), .send_align(send_align),
    .send_sync(send_sync), .link_up(link_up), .link_err(link_err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // gen3 (index 2) for the first window, then gen1 (index 0); gen2 is skipped
  function automatic int exp_spd(int k);
    return (k < WIN) ? 2 : 0;
  endfunction

  task automatic rst_episode(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rst_burst_det = 1;
      @(negedge clk) rst_burst_det = 0;
    end
    @(negedge clk) rst_release_det = 1;
    @(negedge clk) rst_release_det = 0;
  endtask

  task automatic serve(int n, output int ni, output int nw);
    int idle = 0;
    ni = 0; nw = 0;
    while ((ni + nw) < n && idle < 40) begin
      if (init_burst_req || wake_burst_req) begin
        if (init_burst_req) ni++; else nw++;
        idle = 0;
        @(negedge clk) tx_burst_done = 1;
        @(negedge clk) tx_burst_done = 0;
      end else begin
        @(negedge clk);
        idle++;
      end
    end
  endtask

  task automatic bring_up(bit check_it);
    int ni, nw;
    rst_episode(6);
    serve(6, ni, nw);
    if (check_it) chk("R3 init burst count", ni, 6);
    @(negedge clk) wake_release_det = 1;
    @(negedge clk) wake_release_det = 0;
    if (check_it) chk("R4 calibrate strobe", cal_req, 1);
    serve(6, ni, nw);
    if (check_it) begin
      chk("R4 wake burst count", nw, 6);
      chk("R4 no init during wake", ni, 0);
      chk("R4 no align before last done", send_align, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int ni, nw, seen;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {init_burst_req, wake_burst_req, cal_req, send_align,
        send_sync, link_up, link_err}, 0);
    chk("R1 reset speed_sel", speed_sel, 2);

    // R2 sweep of reset episode lengths
    for (int n = 0; n <= 8; n++) begin
      rst_episode(n);
      if (n >= 6) begin
        chk("R2 init starts after long episode", init_burst_req, 1);
        serve(6, ni, nw);
        chk("R3 init burst count", ni, 6);
        seen = 0;
        repeat (10) begin
          @(negedge clk);
          if (init_burst_req || wake_burst_req || send_align) seen++;
        end
        chk("R3 quiet while awaiting wake", seen, 0);
      end else begin
        seen = 0;
        repeat (10) begin
          if (init_burst_req) seen++;
          @(negedge clk);
        end
        chk("R2 short episode ignored", seen, 0);
      end
    end

    // R5 R6 R7 R8: no host answer, D10.2 filler held high
    rx_d10_2 = 1;
    bring_up(1'b1);
    chk("R5 align starts", send_align, 1);
    chk("R5 starts at top speed", speed_sel, 2);
    for (int k = 0; k < 2 * WIN; k++) begin
      chk("R6 R7 align during window", send_align, 1);
      chk("R6 R7 speed per window", speed_sel, exp_spd(k));
      @(negedge clk);
    end
    chk("R8 error after last window", link_err, 1);
    chk("R8 align stops", send_align, 0);
    rx_d10_2 = 0;
    @(negedge clk) begin rx_align = 1; wake_release_det = 1; end
    @(negedge clk) begin rx_align = 0; wake_release_det = 0; end
    repeat (5) @(negedge clk);
    chk("R8 error sticky", link_err, 1);
    chk("R8 no link or requests", {link_up, send_sync, wake_burst_req, cal_req}, 0);

    // R10 abort from error
    @(negedge clk) rst_burst_det = 1;
    @(negedge clk) rst_burst_det = 0;
    chk("R10 error cleared by reset burst", link_err, 0);

    // R9 lock at every offset, R10 abort from an established link
    for (int k = 0; k < 2 * WIN; k++) begin
      if (k > 0) begin
        @(negedge clk) rst_burst_det = 1;
        @(negedge clk) rst_burst_det = 0;
        chk("R10 link dropped by reset burst", link_up, 0);
      end
      bring_up(1'b0);
      repeat (k) @(negedge clk);
      rx_align = 1;
      @(negedge clk) rx_align = 0;
      chk("R9 lock cycle keeps align", {send_align, send_sync}, 2);
      chk("R9 lock speed", speed_sel, exp_spd(k));
      @(negedge clk);
      chk("R9 sync and link up", {send_sync, link_up, send_align}, 6);
      repeat (5) @(negedge clk);
      chk("R9 link held", link_up, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule